// File: doc/BRIEF.md
# Store Drain Buffer for a Write-Through Cache

This block sits between a write-through data cache and the next memory level. Each processor store is queued as an address/data pair and handed to memory in the background, so the processor never waits for memory on a store; it is held back only when every slot of the queue is occupied. A dirty block evicted by the cache controller can be pushed into the same queue. The refill read then does not wait for that write to complete. An evicted block is treated as one data word here.

While stores are pending, a read miss must not fetch stale data from memory. The cache presents the miss address on the lookup port. In the same cycle the block reports whether any pending entry carries that address, and it returns the data of the most recently queued match. Stores that missed the cache follow a no-write-allocate policy: they go only into the queue, and the block tells the cache array to drop that line. Stores that hit are also queued, and the block tells the cache to update the line.

Data flows in on two valid/ready inputs and out on one valid/ready output. An input transfer takes place in a cycle where valid and ready are both high. The input ready signals depend only on occupancy and on the eviction request, and never on the memory side's ready. The output holds its valid, address and data steady until memory accepts it. The depth is a parameter; any depth of at least two is allowed.

Top module: `store_write_buffer`

## Requirements
- R1: After reset the queue holds nothing: `empty`=1, `mem_valid`=0, `lk_hit`=0, and both input ready signals are 1 when no eviction is offered.
- R2: `ev_ready` is 0 exactly when DEPTH (default 4) entries are held. `st_ready` is 0 exactly when DEPTH entries are held or `ev_valid` is 1. An offer made while the queue is full is not taken and does not reach memory later.
- R3: Entries leave in the order they were accepted, one per cycle in which `mem_valid` and `mem_ready` are both 1. `mem_valid` is 1 whenever an entry is held. `mem_addr` and `mem_data` stay unchanged while `mem_valid`=1 and `mem_ready`=0.
- R4: Two accepted stores to the same address are both kept, and both are written to memory in their original order.
- R5: `lk_hit` is 1 in the same cycle that any held entry has an address equal to `lk_addr`. `lk_data` then carries the data of the youngest such entry.
- R6: The lookup covers the head entry even in the cycle it is being written to memory. It does not cover an entry being accepted in the current cycle; that entry becomes visible from the next cycle on.
- R7: A store accepted with `st_hit`=1 raises `cache_wr` for that cycle. A store accepted with `st_hit`=0 raises `cache_inv` instead. Neither signal is high in a cycle without an accepted store.
- R8: When eviction and store are offered in the same cycle, the eviction is taken and the store waits. An accepted eviction raises neither `cache_wr` nor `cache_inv`.
- R9: `empty` is 1 exactly when no entry is held, so a fence may wait on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| st_valid | input | 1 | Processor store offered |
| st_ready | output | 1 | Store can be taken this cycle |
| st_addr | input | ADDR_W | Store word address |
| st_data | input | DATA_W | Store data |
| st_hit | input | 1 | Store address hit in the cache |
| ev_valid | input | 1 | Evicted dirty block offered |
| ev_ready | output | 1 | Eviction can be taken this cycle |
| ev_addr | input | ADDR_W | Evicted block address |
| ev_data | input | DATA_W | Evicted block data |
| mem_valid | output | 1 | Head entry offered to memory |
| mem_ready | input | 1 | Memory accepts the head entry |
| mem_addr | output | ADDR_W | Head entry address |
| mem_data | output | DATA_W | Head entry data |
| lk_addr | input | ADDR_W | Read-miss address to search |
| lk_hit | output | 1 | A pending entry matches `lk_addr` |
| lk_data | output | DATA_W | Data of the youngest matching entry |
| cache_wr | output | 1 | Update the cache line of the accepted store |
| cache_inv | output | 1 | Invalidate the cache line of the accepted store |
| empty | output | 1 | No entries pending |

## Verification
The first directed pattern fills the queue with several stores to one address while memory is stalled. It separates youngest-match forwarding from oldest-match forwarding, and it shows that duplicates are kept instead of merged. The full queue then tests that stall and back-pressure set in at exactly DEPTH entries. Same-cycle eviction and store offers show the eviction priority and the absence of cache-side pulses for evictions. A long random phase mixes stalls and accepts over a small address pool. That phase produces simultaneous push and pop, lookups of the entry leaving memory's port, and lookups of the entry arriving in that cycle. A model queue in the bench predicts every output in every cycle.

// File: rtl/wbuf_pkg.sv
package wbuf_pkg;

  typedef enum logic [1:0] {
    SRC_NONE  = 2'd0,
    SRC_STORE = 2'd1,
    SRC_EVICT = 2'd2
  } wbuf_src_e;

endpackage

// File: rtl/wbuf_ctrl.sv
module wbuf_ctrl
  import wbuf_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             st_valid,
  input  logic             ev_valid,
  input  logic             mem_ready,
  output logic             st_ready,
  output logic             ev_ready,
  output logic             push,
  output logic             pop,
  output wbuf_src_e        src,
  output logic [PTR_W-1:0] wr_ptr,
  output logic [PTR_W-1:0] rd_ptr,
  output logic [CNT_W-1:0] count,
  output logic             empty
);

  localparam logic [PTR_W-1:0] LAST_SLOT = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL_CNT  = CNT_W'(DEPTH);

  logic full;

  assign full  = (count == FULL_CNT);
  assign empty = (count == '0);

  // evictions win over stores so the refill is not held up
  assign ev_ready = !full;
  assign st_ready = !full && !ev_valid;

  always_comb begin
    if (ev_valid && !full)      src = SRC_EVICT;
    else if (st_valid && !full) src = SRC_STORE;
    else                        src = SRC_NONE;
  end

  assign push = (src != SRC_NONE);
  assign pop  = !empty && mem_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= (wr_ptr == LAST_SLOT) ? '0 : wr_ptr + 1'b1;
      if (pop)  rd_ptr <= (rd_ptr == LAST_SLOT) ? '0 : rd_ptr + 1'b1;
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

endmodule

// File: rtl/wbuf_store.sv
module wbuf_store #(
  parameter int DEPTH  = 4,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              push,
  input  logic [PTR_W-1:0]  wr_ptr,
  input  logic [PTR_W-1:0]  rd_ptr,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [DATA_W-1:0] in_data,
  output logic [ADDR_W-1:0] head_addr,
  output logic [DATA_W-1:0] head_data,
  output logic [ADDR_W-1:0] slot_addr [DEPTH],
  output logic [DATA_W-1:0] slot_data [DEPTH]
);

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (push && (wr_ptr == PTR_W'(g))) begin
        slot_addr[g] <= in_addr;
        slot_data[g] <= in_data;
      end
    end
  end

  assign head_addr = slot_addr[rd_ptr];
  assign head_data = slot_data[rd_ptr];

endmodule

// File: rtl/wbuf_match.sv
module wbuf_match #(
  parameter int DEPTH  = 4,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic [ADDR_W-1:0] slot_addr [DEPTH],
  input  logic [DATA_W-1:0] slot_data [DEPTH],
  input  logic [PTR_W-1:0]  rd_ptr,
  input  logic [CNT_W-1:0]  count,
  input  logic [ADDR_W-1:0] lk_addr,
  output logic              lk_hit,
  output logic [DATA_W-1:0] lk_data
);

  logic [DEPTH-1:0] slot_eq;

  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    assign slot_eq[g] = (slot_addr[g] == lk_addr);
  end

  // walk from oldest to youngest; a later match overrides an earlier one
  always_comb begin
    int idx;
    lk_hit  = 1'b0;
    lk_data = '0;
    for (int k = 0; k < DEPTH; k++) begin
      idx = int'(rd_ptr) + k;
      if (idx >= DEPTH) idx = idx - DEPTH;
      if ((k < int'(count)) && slot_eq[idx]) begin
        lk_hit  = 1'b1;
        lk_data = slot_data[idx];
      end
    end
  end

endmodule

// File: rtl/store_write_buffer.sv
module store_write_buffer
  import wbuf_pkg::*;
#(
  parameter int DEPTH  = 4,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              st_valid,
  output logic              st_ready,
  input  logic [ADDR_W-1:0] st_addr,
  input  logic [DATA_W-1:0] st_data,
  input  logic              st_hit,
  input  logic              ev_valid,
  output logic              ev_ready,
  input  logic [ADDR_W-1:0] ev_addr,
  input  logic [DATA_W-1:0] ev_data,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_data,
  input  logic [ADDR_W-1:0] lk_addr,
  output logic              lk_hit,
  output logic [DATA_W-1:0] lk_data,
  output logic              cache_wr,
  output logic              cache_inv,
  output logic              empty
);

  logic              push;
  logic              pop;
  wbuf_src_e         src;
  logic [PTR_W-1:0]  wr_ptr;
  logic [PTR_W-1:0]  rd_ptr;
  logic [CNT_W-1:0]  count;
  logic [ADDR_W-1:0] in_addr;
  logic [DATA_W-1:0] in_data;
  logic [ADDR_W-1:0] slot_addr [DEPTH];
  logic [DATA_W-1:0] slot_data [DEPTH];
  logic              st_take;

  wbuf_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .st_valid  (st_valid),
    .ev_valid  (ev_valid),
    .mem_ready (mem_ready),
    .st_ready  (st_ready),
    .ev_ready  (ev_ready),
    .push      (push),
    .pop       (pop),
    .src       (src),
    .wr_ptr    (wr_ptr),
    .rd_ptr    (rd_ptr),
    .count     (count),
    .empty     (empty)
  );

  always_comb begin
    if (src == SRC_EVICT) begin
      in_addr = ev_addr;
      in_data = ev_data;
    end else begin
      in_addr = st_addr;
      in_data = st_data;
    end
  end

  wbuf_store #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
    .clk       (clk),
    .push      (push),
    .wr_ptr    (wr_ptr),
    .rd_ptr    (rd_ptr),
    .in_addr   (in_addr),
    .in_data   (in_data),
    .head_addr (mem_addr),
    .head_data (mem_data),
    .slot_addr (slot_addr),
    .slot_data (slot_data)
  );

  wbuf_match #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_match (
    .slot_addr (slot_addr),
    .slot_data (slot_data),
    .rd_ptr    (rd_ptr),
    .count     (count),
    .lk_addr   (lk_addr),
    .lk_hit    (lk_hit),
    .lk_data   (lk_data)
  );

  assign mem_valid = !empty;
  assign st_take   = (src == SRC_STORE);
  assign cache_wr  = st_take && st_hit;
  assign cache_inv = st_take && !st_hit;

endmodule

// File: rtl/wbuf_checker.sv
module wbuf_checker #(
  parameter int DEPTH  = 4,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              st_valid,
  input logic              st_ready,
  input logic              ev_valid,
  input logic              ev_ready,
  input logic              mem_valid,
  input logic              mem_ready,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_data,
  input logic              lk_hit,
  input logic              cache_wr,
  input logic              cache_inv,
  input logic              empty,
  input logic [CNT_W-1:0]  count
);

  // R2
  full_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (count == CNT_W'(DEPTH)) |-> (!ev_ready && !st_ready));

  // R2
  room_accepts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (count < CNT_W'(DEPTH)) |-> ev_ready);

  // R2
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (((st_valid && st_ready) || (ev_valid && ev_ready)) && !(mem_valid && mem_ready))
      |=> (count == $past(count) + 1'b1));

  // R3
  head_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_data)));

  // R9
  empty_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> (!mem_valid && !lk_hit));

  // R7
  cache_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cache_wr, cache_inv}));

  // R7
  cache_needs_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cache_wr || cache_inv) |-> (st_valid && st_ready));

  // R8
  evict_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid |-> !st_ready);

endmodule

bind store_write_buffer wbuf_checker #(
  .DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .st_valid  (st_valid),
  .st_ready  (st_ready),
  .ev_valid  (ev_valid),
  .ev_ready  (ev_ready),
  .mem_valid (mem_valid),
  .mem_ready (mem_ready),
  .mem_addr  (mem_addr),
  .mem_data  (mem_data),
  .lk_hit    (lk_hit),
  .cache_wr  (cache_wr),
  .cache_inv (cache_inv),
  .empty     (empty),
  .count     (count)
);

// File: tb/store_write_buffer_tb.sv
module store_write_buffer_tb;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH  = 4;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 32;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              st_valid = 1'b0, st_hit = 1'b0, ev_valid = 1'b0, mem_ready = 1'b0;
  logic [ADDR_W-1:0] st_addr = '0, ev_addr = '0, lk_addr = '0;
  logic [DATA_W-1:0] st_data = '0, ev_data = '0;
  logic              st_ready, ev_ready, mem_valid, lk_hit, cache_wr, cache_inv, empty;
  logic [ADDR_W-1:0] mem_addr;
  logic [DATA_W-1:0] mem_data;

  int n_checks = 0;
  int n_fails  = 0;

  logic [ADDR_W-1:0] m_addr [8];
  logic [DATA_W-1:0] m_data [8];
  int                m_n = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  store_write_buffer #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .st_valid(st_valid), .st_ready(st_ready), .st_addr(st_addr), .st_data(st_data), .st_hit(st_hit),
    .ev_valid(ev_valid), .ev_ready(ev_ready), .ev_addr(ev_addr), .ev_data(ev_data),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr), .mem_data(mem_data),
    .lk_addr(lk_addr), .lk_hit(lk_hit), .lk_data(lk_data_w),
    .cache_wr(cache_wr), .cache_inv(cache_inv), .empty(empty)
  );

  logic [DATA_W-1:0] lk_data_w;

  function automatic logic model_hit(input logic [ADDR_W-1:0] a);
    logic h = 1'b0;
    for (int i = 0; i < m_n; i++) if (m_addr[i] == a) h = 1'b1;
    return h;
  endfunction

  function automatic logic [DATA_W-1:0] model_youngest(input logic [ADDR_W-1:0] a);
    logic [DATA_W-1:0] d = '0;
    for (int i = 0; i < m_n; i++) if (m_addr[i] == a) d = m_data[i];
    return d;
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input logic sv, input logic [ADDR_W-1:0] sa, input logic [DATA_W-1:0] sd,
                      input logic sh, input logic evv, input logic [ADDR_W-1:0] ea,
                      input logic [DATA_W-1:0] ed, input logic mr, input logic [ADDR_W-1:0] la);
    logic full, ev_acc, st_acc, pop;
    @(negedge clk);
    st_valid = sv; st_addr = sa; st_data = sd; st_hit = sh;
    ev_valid = evv; ev_addr = ea; ev_data = ed; mem_ready = mr; lk_addr = la;
    #1;
    full   = (m_n == DEPTH);
    ev_acc = evv && !full;
    st_acc = sv && !full && !evv;
    pop    = (m_n > 0) && mr;
    chk("R2 ev_ready", 64'(ev_ready), 64'(!full));
    chk("R2 R8 st_ready", 64'(st_ready), 64'(!full && !evv));
    chk("R3 mem_valid", 64'(mem_valid), 64'(m_n > 0));
    if (m_n > 0) begin
      chk("R3 R4 mem_addr order", 64'(mem_addr), 64'(m_addr[0]));
      chk("R3 R4 mem_data order", 64'(mem_data), 64'(m_data[0]));
    end
    chk("R5 R6 lk_hit", 64'(lk_hit), 64'(model_hit(la)));
    if (model_hit(la)) chk("R5 youngest lk_data", 64'(lk_data_w), 64'(model_youngest(la)));
    chk("R9 empty", 64'(empty), 64'(m_n == 0));
    chk("R7 R8 cache_wr", 64'(cache_wr), 64'(st_acc && sh));
    chk("R7 R8 cache_inv", 64'(cache_inv), 64'(st_acc && !sh));
    @(posedge clk);
    if (pop) begin
      for (int i = 0; i < m_n - 1; i++) begin
        m_addr[i] = m_addr[i+1];
        m_data[i] = m_data[i+1];
      end
      m_n--;
    end
    if (ev_acc) begin
      m_addr[m_n] = ea; m_data[m_n] = ed; m_n++;
    end else if (st_acc) begin
      m_addr[m_n] = sa; m_data[m_n] = sd; m_n++;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fails++;
    $display("FAIL R3 watchdog expired, run did not finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: idle after reset
    step(0, 0, 0, 0, 0, 0, 0, 0, 16'h0040);

    // R6: lookup of the store being accepted misses this cycle
    step(1, 16'h0040, 32'hA1, 1, 0, 0, 0, 0, 16'h0040);
    // R4 R5: same address stored repeatedly while memory stalls
    step(1, 16'h0040, 32'hA2, 0, 0, 0, 0, 0, 16'h0040);
    step(1, 16'h0040, 32'hA3, 1, 0, 0, 0, 0, 16'h0040);
    step(1, 16'h0040, 32'hA4, 0, 0, 0, 0, 0, 16'h0040);
    // R2: full, further offers refused
    step(1, 16'h0044, 32'hBAD, 1, 0, 0, 0, 0, 16'h0040);
    step(0, 0, 0, 0, 1, 16'h0048, 32'hBAD2, 0, 16'h0044);
    // R6: head still visible while it drains
    step(0, 0, 0, 0, 0, 0, 0, 1, 16'h0040);
    // R8: eviction and store together, eviction taken
    step(1, 16'h0050, 32'hC1, 1, 1, 16'h0060, 32'hE1, 0, 16'h0060);
    step(1, 16'h0050, 32'hC1, 0, 0, 0, 0, 1, 16'h0050);
    // R3 R9: drain to empty
    repeat (6) step(0, 0, 0, 0, 0, 0, 0, 1, 16'h0050);

    // random phase
    for (int n = 0; n < 4000; n++) begin
      logic [ADDR_W-1:0] ra, rea, rla;
      ra  = ADDR_W'(16'h0010 + 4 * ($urandom % 4));
      rea = ADDR_W'(16'h0010 + 4 * ($urandom % 4));
      rla = ADDR_W'(16'h0010 + 4 * ($urandom % 5));
      step(($urandom % 10) < 6, ra, $urandom, $urandom % 2,
           ($urandom % 10) < 2, rea, $urandom,
           ($urandom % 10) < 4, rla);
    end

    repeat (8) step(0, 0, 0, 0, 0, 0, 0, 1, 16'h0010);

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

endmodule